// File: doc/BRIEF.md
# Egress Parity Error Injector

This block sits in line with a multi-port packet egress bus where each transfer cycle carries a parity bit. A cycle with the start-of-transfer flag set carries an in-band logical port number in its low data bits. Every other valid cycle is a data cycle, and it belongs to the port named by the most recent address cycle. The block produces odd parity for each outgoing cycle and passes the bus fields through with one register stage of delay.

Software uses one control register to test the parity checking at the far end. The register holds a target port and two arm bits. One arm bit corrupts the parity of the next address cycle that names the target port. The other corrupts the parity of the next data cycle that belongs to that port. Each arm bit makes exactly one error, then clears itself, so software can read the register back to see that the error has gone out.

Top module: `egress_parity_injector`

## Requirements
- R1: When no error is injected, `outParity` is the odd parity of `outData`: the XOR of every `outData` bit and `outParity` is 1. `outValid`, `outSoc` and `outData` repeat `txValid`, `txSoc` and `txData` one clock later.
- R2: Control register layout, on both write and read. Bit 0 is the address-error arm. Bit 1 is the data-error arm. Bits [PORT_W+1:2] are the target port. `regRdData` shows the current state without delay.
- R3: An arm bit is set by writing 1 to it. Writing 0 to an arm bit leaves a pending arm unchanged. Every write loads the target field.
- R4: An armed address error inverts the parity of exactly one cycle: the first valid cycle with `txSoc`=1 whose `txData[PORT_W-1:0]` equals the target port. Address cycles naming other ports and all data cycles keep correct parity.
- R5: An armed data error inverts the parity of the first valid cycle with `txSoc`=0 whose current port equals the target port. Data cycles seen before any address cycle since reset belong to no port and never match.
- R6: An arm bit clears on the clock edge that captures its injected cycle. A write made on that same edge does not keep it set.
- R7: When both arm bits are set, each is serviced on its own matching cycle and clears on its own.
- R8: Writing 1 to an arm bit that is already pending has no effect. One arming produces one error.
- R9: Reset clears both arm bits, sets the target port to 0 and drives `outValid` low.
- R10: Port values across the full range 0 to 2^PORT_W-1 are matched, including the all-ones port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Control register write strobe |
| regWrData | input | PORT_W+2 | Control register write value |
| regRdData | output | PORT_W+2 | Control register read value |
| txValid | input | 1 | Incoming cycle valid |
| txSoc | input | 1 | Incoming cycle carries a port address |
| txData | input | DATA_W | Incoming data bus |
| outValid | output | 1 | Outgoing cycle valid |
| outSoc | output | 1 | Outgoing address flag |
| outData | output | DATA_W | Outgoing data bus |
| outParity | output | 1 | Outgoing odd parity, inverted on an injected cycle |

## Verification
Results on the bus side come due one clock after the input cycle. The bench drives each cycle on the falling edge and samples `outParity` and `outData` shortly after the next rising edge. Arm bits change on that same rising edge, and `regRdData` is combinational, so the readback is checked in the same sample. A write and a bus cycle in the same clock therefore show that an arm only takes effect from the following cycle.

// File: rtl/pinj_pkg.sv
package pinj_pkg;
  // path -> control: which arm condition the current input cycle satisfies
  typedef struct packed {
    logic addrHit;
    logic dataHit;
  } pinj_hit_t;

  // control -> path: one-cycle strobes that invert the parity bit
  typedef struct packed {
    logic injAddr;
    logic injData;
  } pinj_strobe_t;
endpackage

// File: rtl/pinjCtrl.sv
module pinjCtrl
  import pinj_pkg::*;
#(
  parameter int PORT_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWrEn,
  input  logic [PORT_W+1:0]   regWrData,
  output logic [PORT_W+1:0]   regRdData,
  input  pinj_hit_t           hit,
  output pinj_strobe_t        strobe,
  output logic [PORT_W-1:0]   target
);
  localparam int ADDR_BIT = 0;
  localparam int DATA_BIT = 1;

  logic addrArm;
  logic dataArm;

  assign strobe.injAddr = addrArm & hit.addrHit;
  assign strobe.injData = dataArm & hit.dataHit;
  assign regRdData      = {target, dataArm, addrArm};

  // A pending arm only leaves by injection; an idle arm only enters by a written 1.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrArm <= 1'b0;
      dataArm <= 1'b0;
      target  <= '0;
    end else begin
      if (regWrEn) target <= regWrData[PORT_W+1:2];
      addrArm <= addrArm ? !hit.addrHit : (regWrEn & regWrData[ADDR_BIT]);
      dataArm <= dataArm ? !hit.dataHit : (regWrEn & regWrData[DATA_BIT]);
    end
  end

  // R6: after an injection the arm is gone
  assert_addr_clears_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.injAddr |=> !addrArm);
  assert_data_clears_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.injData |=> !dataArm);
  // R8: an arm disappears only through its own injection
  assert_addr_fall_R8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(addrArm) |-> $past(hit.addrHit));
  assert_data_fall_R8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(dataArm) |-> $past(hit.dataHit));
endmodule

// File: rtl/pinjPath.sv
module pinjPath
  import pinj_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int PORT_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               txValid,
  input  logic               txSoc,
  input  logic [DATA_W-1:0]  txData,
  input  logic [PORT_W-1:0]  target,
  input  pinj_strobe_t       strobe,
  output pinj_hit_t          hit,
  output logic               outValid,
  output logic               outSoc,
  output logic [DATA_W-1:0]  outData,
  output logic               outParity
);
  logic [PORT_W-1:0] curPort;
  logic              portKnown;
  logic              oddPar;

  assign oddPar      = ~(^txData);
  assign hit.addrHit = txValid & txSoc & (txData[PORT_W-1:0] == target);
  assign hit.dataHit = txValid & !txSoc & portKnown & (curPort == target);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curPort   <= '0;
      portKnown <= 1'b0;
      outValid  <= 1'b0;
      outSoc    <= 1'b0;
      outData   <= '0;
      outParity <= 1'b1;
    end else begin
      if (txValid && txSoc) begin
        curPort   <= txData[PORT_W-1:0];
        portKnown <= 1'b1;
      end
      outValid  <= txValid;
      outSoc    <= txSoc;
      outData   <= txData;
      outParity <= oddPar ^ (strobe.injAddr | strobe.injData);
    end
  end

  // R1: bad parity on the output only after an injection strobe
  assert_parity_ok_R1: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && (outParity == ^outData)) |-> $past(strobe.injAddr || strobe.injData));
  // R4: address strobes only on address cycles
  assert_addr_on_soc_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.injAddr |-> (txValid && txSoc));
  // R5: data strobes only on data cycles
  assert_data_off_soc_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.injData |-> (txValid && !txSoc));
endmodule

// File: rtl/egress_parity_injector.sv
module egress_parity_injector
  import pinj_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int PORT_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic [PORT_W+1:0]  regWrData,
  output logic [PORT_W+1:0]  regRdData,
  input  logic               txValid,
  input  logic               txSoc,
  input  logic [DATA_W-1:0]  txData,
  output logic               outValid,
  output logic               outSoc,
  output logic [DATA_W-1:0]  outData,
  output logic               outParity
);
  pinj_hit_t         hit;
  pinj_strobe_t      strobe;
  logic [PORT_W-1:0] target;

  pinjCtrl #(.PORT_W(PORT_W)) uCtrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .hit(hit), .strobe(strobe), .target(target)
  );

  pinjPath #(.DATA_W(DATA_W), .PORT_W(PORT_W)) uPath (
    .clk(clk), .rstN(rstN), .txValid(txValid), .txSoc(txSoc), .txData(txData),
    .target(target), .strobe(strobe), .hit(hit), .outValid(outValid),
    .outSoc(outSoc), .outData(outData), .outParity(outParity)
  );
endmodule

// File: tb/sim_egress_parity_injector.sv
module sim_egress_parity_injector;
  localparam int DATA_W = 32;
  localparam int PORT_W = 8;
  localparam int RW = PORT_W + 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic [RW-1:0] regWrData = '0;
  logic [RW-1:0] regRdData;
  logic txValid = 1'b0;
  logic txSoc = 1'b0;
  logic [DATA_W-1:0] txData = '0;
  logic outValid, outSoc, outParity;
  logic [DATA_W-1:0] outData;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  egress_parity_injector #(.DATA_W(DATA_W), .PORT_W(PORT_W)) u0 (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .txValid(txValid), .txSoc(txSoc), .txData(txData),
    .outValid(outValid), .outSoc(outSoc), .outData(outData), .outParity(outParity)
  );

  typedef struct packed {
    logic          wr;
    logic [RW-1:0] wdata;
    logic          v;
    logic          s;
    logic [DATA_W-1:0] d;
    logic          par;
    logic [RW-1:0] rd;
  } vec_t;

  // register value = {port, dataArm, addrArm}
  localparam vec_t VECS [17] = '{
    '{1'b1, 10'h015, 1'b0, 1'b0, 32'h0, 1'b0, 10'h015}, // arm addr error, port 5
    '{1'b0, 10'h000, 1'b1, 1'b1, 32'h3, 1'b1, 10'h015}, // addr port 3: no hit
    '{1'b0, 10'h000, 1'b1, 1'b0, 32'h1, 1'b0, 10'h015}, // data: no addr effect
    '{1'b0, 10'h000, 1'b1, 1'b1, 32'h5, 1'b0, 10'h014}, // addr port 5: injected
    '{1'b0, 10'h000, 1'b1, 1'b1, 32'h5, 1'b1, 10'h014}, // only once
    '{1'b1, 10'h016, 1'b1, 1'b0, 32'h0, 1'b1, 10'h016}, // arm data while data passes
    '{1'b0, 10'h000, 1'b1, 1'b0, 32'h0, 1'b0, 10'h014}, // data port 5: injected
    '{1'b0, 10'h000, 1'b1, 1'b0, 32'h0, 1'b1, 10'h014}, // only once
    '{1'b1, 10'h01F, 1'b0, 1'b0, 32'h0, 1'b0, 10'h01F}, // both armed, port 7
    '{1'b0, 10'h000, 1'b1, 1'b0, 32'h1, 1'b0, 10'h01F}, // data of port 5: no hit
    '{1'b0, 10'h000, 1'b1, 1'b1, 32'h7, 1'b1, 10'h01E}, // addr port 7: injected
    '{1'b0, 10'h000, 1'b1, 1'b0, 32'h1, 1'b1, 10'h01C}, // data port 7: injected
    '{1'b1, 10'h01D, 1'b0, 1'b0, 32'h0, 1'b0, 10'h01D}, // arm addr
    '{1'b1, 10'h01C, 1'b0, 1'b0, 32'h0, 1'b0, 10'h01D}, // write 0: stays
    '{1'b1, 10'h01D, 1'b0, 1'b0, 32'h0, 1'b0, 10'h01D}, // re-arm while pending
    '{1'b0, 10'h000, 1'b1, 1'b1, 32'h7, 1'b1, 10'h01C}, // single injection
    '{1'b0, 10'h000, 1'b1, 1'b1, 32'h7, 1'b0, 10'h01C}  // no second error
  };

  task automatic check(input string req, input string what, input logic [DATA_W-1:0] act,
                       input logic [DATA_W-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step(input logic wr, input logic [RW-1:0] wd, input logic v,
                      input logic s, input logic [DATA_W-1:0] d);
    @(negedge clk);
    regWrEn = wr; regWrData = wd; txValid = v; txSoc = s; txData = d;
    @(posedge clk);
    #1;
    @(negedge clk);
    regWrEn = 1'b0; txValid = 1'b0; txSoc = 1'b0;
    #0;
  endtask

  // sample point: 1 ns after the rising edge that captured the cycle
  task automatic cyc(input logic wr, input logic [RW-1:0] wd, input logic v,
                     input logic s, input logic [DATA_W-1:0] d);
    @(negedge clk);
    regWrEn = wr; regWrData = wd; txValid = v; txSoc = s; txData = d;
    @(posedge clk);
    #1;
  endtask

  task automatic doReset();
    @(negedge clk);
    regWrEn = 1'b0; txValid = 1'b0; txSoc = 1'b0; txData = '0;
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    doReset();
    #1;
    check("R9", "arms/target after reset", DATA_W'(regRdData), 0);
    check("R9", "outValid after reset", DATA_W'(outValid), 0);

    foreach (VECS[i]) begin
      cyc(VECS[i].wr, VECS[i].wdata, VECS[i].v, VECS[i].s, VECS[i].d);
      check("R2", $sformatf("vec %0d readback", i), DATA_W'(regRdData), DATA_W'(VECS[i].rd));
      check("R1", $sformatf("vec %0d outValid", i), DATA_W'(outValid), DATA_W'(VECS[i].v));
      if (VECS[i].v) begin
        check("R1", $sformatf("vec %0d outData", i), outData, VECS[i].d);
        check("R1", $sformatf("vec %0d outSoc", i), DATA_W'(outSoc), DATA_W'(VECS[i].s));
        check("R4 R5 R7 R8", $sformatf("vec %0d parity", i), DATA_W'(outParity),
              DATA_W'(VECS[i].par));
      end
    end

    // R10: all-ones port
    cyc(1'b1, 10'h3FD, 1'b0, 1'b0, 32'h0);
    check("R10", "arm port FF", DATA_W'(regRdData), 32'h3FD);
    cyc(1'b0, 10'h0, 1'b1, 1'b1, 32'h0000_00FE);
    check("R10", "addr port FE no hit", DATA_W'(outParity), 32'h0);
    cyc(1'b0, 10'h0, 1'b1, 1'b1, 32'h0000_00FF);
    check("R10", "addr port FF injected", DATA_W'(outParity), 32'h0);
    check("R6", "addr arm cleared", DATA_W'(regRdData), 32'h3FC);

    // R6: write of 1 on the injecting edge does not keep the arm
    cyc(1'b1, 10'h3FD, 1'b0, 1'b0, 32'h0);
    cyc(1'b1, 10'h3FD, 1'b1, 1'b1, 32'h0000_00FF);
    check("R6", "inject with simultaneous write", DATA_W'(outParity), 32'h0);
    check("R6", "arm cleared despite write", DATA_W'(regRdData), 32'h3FC);

    // R9 and R5: reset clears state; data before any address belongs to no port
    cyc(1'b1, 10'h3FE, 1'b0, 1'b0, 32'h0);
    doReset();
    #1;
    check("R9", "reset clears pending arm", DATA_W'(regRdData), 0);
    cyc(1'b1, 10'h002, 1'b0, 1'b0, 32'h0);
    cyc(1'b0, 10'h0, 1'b1, 1'b0, 32'h0);
    check("R5", "data before address: no inject", DATA_W'(outParity), 32'h1);
    check("R5", "arm still pending", DATA_W'(regRdData), 32'h002);
    cyc(1'b0, 10'h0, 1'b1, 1'b1, 32'h0);
    check("R4", "addr port 0 without addr arm", DATA_W'(outParity), 32'h1);
    cyc(1'b0, 10'h0, 1'b1, 1'b0, 32'h0);
    check("R5", "data port 0 injected", DATA_W'(outParity), 32'h0);
    check("R3", "data arm cleared", DATA_W'(regRdData), 32'h0);
    step(1'b0, 10'h0, 1'b0, 1'b0, 32'h0);

    finished = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end
endmodule